// File: doc/BRIEF.md
# SCL Divider and Phase Timing Generator

This block turns a requested divide ratio into the timing of a two-wire serial clock. The ratio is the input clock frequency divided by the wanted bus rate. The block reduces the ratio to a power-of-two prescale exponent and a residue below sixteen, rounding up so the bus is never faster than asked. It then splits the residue into a high-phase count and a low-phase count, and it drives a free-running SCL level built from those counts.

A new ratio is offered on a valid/ready pair. Ready is low while a reduction is in progress, and an offered ratio waits until ready returns. The block accepts a ratio on the first rising edge where valid and ready are both high. It ignores a ratio of zero. The three fields are registered outputs. A done flag marks them valid. The phase generator restarts from the start of a high phase whenever new fields are committed.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, fields_done is 0, base_exp, scl_hi_cnt and scl_lo_cnt are 0, ratio_ready is 1, scl_level is 1 and base_tick is 0.
- R2: base_exp is the smallest e such that ratio >> e is below 16. The reduction takes one shift per clock.
- R3: The reduced ratio is (ratio >> base_exp) plus 1 if any shifted-out bit was 1. This is a division rounded up, and it can reach 16.
- R4: scl_lo_cnt equals (reduced ratio >> 1) - 1 and is 4 bits wide.
- R5: scl_hi_cnt equals reduced ratio - scl_lo_cnt - 2. For any ratio of 2 or more, neither field wraps.
- R6: An accepted ratio of 0 leaves the fields, fields_done and ratio_ready unchanged.
- R7: ratio_ready is 0 from the acceptance edge of a ratio of 16 or more until the fields are committed. An offered ratio is taken only on an edge where ratio_ready is 1.
- R8: While running, base_tick pulses for one cycle every 2^base_exp clock cycles.
- R9: After a commit, scl_level is high for (scl_hi_cnt+1) base ticks, then low for (scl_lo_cnt+1) base ticks, and this repeats.
- R10: The fields are committed base_exp+1 edges after acceptance. A ratio below 16 is committed on its acceptance edge. fields_done is 0 while the reduction runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio_valid | input | 1 | Ratio offered |
| ratio_ready | output | 1 | Block can take a ratio |
| ratio | input | RATIO_W (16) | Requested input-clock-to-bus-rate ratio |
| base_exp | output | EXP_W (4) | Power-of-two prescale exponent |
| scl_hi_cnt | output | 4 | High-phase count (phase lasts count+1 base ticks) |
| scl_lo_cnt | output | 4 | Low-phase count (phase lasts count+1 base ticks) |
| fields_done | output | 1 | Fields valid |
| scl_level | output | 1 | Current SCL phase, 1 = high |
| base_tick | output | 1 | One-cycle pulse per prescaled base tick |

## Verification
The field-range assertions assume that every accepted non-zero ratio is at least 2. Below that, the low field wraps by definition. The stimulus therefore offers only zero or ratios of 4 and up. The stimulus changes the offered ratio while ready is low, to show that nothing is taken during a reduction. Pattern lengths are measured only for exponents up to 6. This keeps each measured period within about a thousand cycles, while the largest ratio still exercises the longest reduction.

// File: rtl/scl_timing_pkg.sv
`timescale 1ns/1ps
package scl_timing_pkg;
  localparam int FIELD_W = 4;
  localparam int WINDOW  = 1 << FIELD_W;
  typedef logic [FIELD_W-1:0] field_t;
endpackage

// File: rtl/scl_ratio_reducer.sv
`timescale 1ns/1ps
module scl_ratio_reducer
  import scl_timing_pkg::*;
#(
  parameter int RATIO_W = 16,
  parameter int EXP_W   = $clog2(RATIO_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [RATIO_W-1:0] in_ratio,
  output logic [EXP_W-1:0]   exp_o,
  output field_t             hi_o,
  output field_t             lo_o,
  output logic               done_o,
  output logic               commit_o
);
  logic               busy;
  logic [RATIO_W-1:0] work;
  logic               sticky;
  logic [EXP_W-1:0]   exp_w;

  logic               take, active, big;
  logic [RATIO_W-1:0] cur_work;
  logic               cur_sticky;
  logic [EXP_W-1:0]   cur_exp;
  logic [FIELD_W:0]   red;
  field_t             lo_c, hi_c;

  assign in_ready = !busy;
  assign take     = in_valid && in_ready && (in_ratio != '0);
  assign active   = take || busy;

  always_comb begin
    cur_work   = take ? in_ratio : work;
    cur_sticky = take ? 1'b0     : sticky;
    cur_exp    = take ? '0       : exp_w;
    big        = |cur_work[RATIO_W-1:FIELD_W];
    red        = {1'b0, cur_work[FIELD_W-1:0]} + {{FIELD_W{1'b0}}, cur_sticky};
    lo_c       = red[FIELD_W:1] - field_t'(1);
    hi_c       = red[FIELD_W-1:0] - lo_c - field_t'(2);
  end

  assign commit_o = active && !big;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      work   <= '0;
      sticky <= 1'b0;
      exp_w  <= '0;
      exp_o  <= '0;
      hi_o   <= '0;
      lo_o   <= '0;
      done_o <= 1'b0;
    end else if (active) begin
      if (big) begin
        busy   <= 1'b1;
        work   <= cur_work >> 1;
        sticky <= cur_sticky | cur_work[0];
        exp_w  <= cur_exp + EXP_W'(1);
        done_o <= 1'b0;
      end else begin
        busy   <= 1'b0;
        exp_o  <= cur_exp;
        hi_o   <= hi_c;
        lo_o   <= lo_c;
        done_o <= 1'b1;
      end
    end
  end

  p_zero_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_ratio == '0) |=>
      ($stable(exp_o) && $stable(hi_o) && $stable(lo_o) && $stable(done_o) && in_ready));

  p_not_done_while_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !done_o);

  p_lo_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (lo_o <= field_t'(WINDOW/2 - 1)));

  p_span_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (({1'b0, hi_o} + {1'b0, lo_o} + 5'd2) <= 5'(WINDOW)));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(exp_o) && $stable(hi_o) && $stable(lo_o)));
endmodule

// File: rtl/scl_phase_gen.sv
`timescale 1ns/1ps
module scl_phase_gen
  import scl_timing_pkg::*;
#(
  parameter int RATIO_W = 16,
  parameter int EXP_W   = $clog2(RATIO_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [EXP_W-1:0] exp_i,
  input  field_t           hi_i,
  input  field_t           lo_i,
  output logic             level_o,
  output logic             tick_o
);
  logic               running;
  logic [RATIO_W-1:0] pcnt;
  logic [RATIO_W-1:0] mask;
  field_t             pc;
  field_t             limit;

  assign mask   = (RATIO_W'(1) << exp_i) - RATIO_W'(1);
  assign tick_o = running && (pcnt == mask);
  assign limit  = level_o ? hi_i : lo_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pcnt    <= '0;
      pc      <= '0;
      level_o <= 1'b1;
    end else if (restart) begin
      running <= 1'b1;
      pcnt    <= '0;
      pc      <= '0;
      level_o <= 1'b1;
    end else if (running) begin
      if (tick_o) begin
        pcnt <= '0;
        if (pc == limit) begin
          level_o <= ~level_o;
          pc      <= '0;
        end else begin
          pc <= pc + field_t'(1);
        end
      end else begin
        pcnt <= pcnt + RATIO_W'(1);
      end
    end
  end

  p_prescale_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pcnt <= mask));

  p_phase_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pc <= limit));

  p_toggle_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !restart && !tick_o) |=> $stable(level_o));
endmodule

// File: rtl/scl_timing_gen.sv
`timescale 1ns/1ps
module scl_timing_gen
  import scl_timing_pkg::*;
#(
  parameter int RATIO_W = 16,
  parameter int EXP_W   = $clog2(RATIO_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ratio_valid,
  output logic               ratio_ready,
  input  logic [RATIO_W-1:0] ratio,
  output logic [EXP_W-1:0]   base_exp,
  output logic [FIELD_W-1:0] scl_hi_cnt,
  output logic [FIELD_W-1:0] scl_lo_cnt,
  output logic               fields_done,
  output logic               scl_level,
  output logic               base_tick
);
  logic commit;

  scl_ratio_reducer #(.RATIO_W(RATIO_W), .EXP_W(EXP_W)) u_reduce (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (ratio_valid),
    .in_ready (ratio_ready),
    .in_ratio (ratio),
    .exp_o    (base_exp),
    .hi_o     (scl_hi_cnt),
    .lo_o     (scl_lo_cnt),
    .done_o   (fields_done),
    .commit_o (commit)
  );

  scl_phase_gen #(.RATIO_W(RATIO_W), .EXP_W(EXP_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (commit),
    .exp_i   (base_exp),
    .hi_i    (scl_hi_cnt),
    .lo_i    (scl_lo_cnt),
    .level_o (scl_level),
    .tick_o  (base_tick)
  );

  p_commit_sets_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (fields_done && scl_level && ratio_ready));
endmodule

// File: tb/scl_timing_gen_test.sv
`timescale 1ns/1ps
module scl_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ratio_valid = 1'b0;
  logic        ratio_ready;
  logic [15:0] ratio = '0;
  logic [3:0]  base_exp, scl_hi_cnt, scl_lo_cnt;
  logic        fields_done, scl_level, base_tick;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  scl_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .ratio_valid(ratio_valid), .ratio_ready(ratio_ready),
    .ratio(ratio), .base_exp(base_exp), .scl_hi_cnt(scl_hi_cnt), .scl_lo_cnt(scl_lo_cnt),
    .fields_done(fields_done), .scl_level(scl_level), .base_tick(base_tick)
  );

  localparam int NV = 10;
  localparam logic [15:0] V_RATIO [NV] = '{16'd4, 16'd15, 16'd16, 16'd17, 16'd31,
                                          16'd32, 16'd100, 16'd255, 16'd1000, 16'd65535};
  localparam int V_EXP [NV] = '{0, 0, 1, 1, 1, 2, 3, 4, 6, 12};
  localparam int V_LO  [NV] = '{1, 6, 3, 3, 7, 3, 5, 7, 7, 7};
  localparam int V_HI  [NV] = '{1, 7, 3, 4, 7, 3, 6, 7, 7, 7};

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // offer a ratio and return once it has been taken (at the negedge after acceptance)
  task automatic offer(input logic [15:0] r);
    bit taken;
    ratio = r;
    ratio_valid = 1'b1;
    taken = 0;
    while (!taken) begin
      if (ratio_ready) taken = 1;
      @(negedge clk);
    end
    ratio_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int lat, hrun, lrun, tks;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 done", fields_done, 0);
    check("R1 exp", base_exp, 0);
    check("R1 hi", scl_hi_cnt, 0);
    check("R1 lo", scl_lo_cnt, 0);
    check("R1 ready", ratio_ready, 1);
    check("R1 level", scl_level, 1);
    check("R1 tick", base_tick, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      offer(V_RATIO[i]);
      lat = 1;
      if (V_EXP[i] > 0) check("R10 done low while reducing", fields_done, 0);
      while (!fields_done && lat < 40) begin
        @(negedge clk);
        lat++;
      end
      check("R10 latency", lat, V_EXP[i] + 1);
      check("R2 exponent", base_exp, V_EXP[i]);
      check("R4 low field", scl_lo_cnt, V_LO[i]);
      check("R5 high field", scl_hi_cnt, V_HI[i]);
      if (V_EXP[i] <= 6) begin
        hrun = 0; lrun = 0; tks = 0;
        while (scl_level && hrun < 5000) begin
          hrun++;
          if (base_tick) tks++;
          @(negedge clk);
        end
        while (!scl_level && lrun < 5000) begin
          lrun++;
          @(negedge clk);
        end
        check("R9 high run", hrun, (V_HI[i] + 1) << V_EXP[i]);
        check("R9 low run", lrun, (V_LO[i] + 1) << V_EXP[i]);
        check("R8 ticks in high phase", tks, V_HI[i] + 1);
        // R3: total period is the rounded-up reduced ratio times 2^exp
        check("R3 period", hrun + lrun,
              ((int'(V_RATIO[i]) + (1 << V_EXP[i]) - 1) >> V_EXP[i]) << V_EXP[i]);
      end
    end

    // R6 zero ignored (fields hold 12/7/7 from 65535)
    offer(16'd0);
    check("R6 exp held", base_exp, 12);
    check("R6 lo held", scl_lo_cnt, 7);
    check("R6 hi held", scl_hi_cnt, 7);
    check("R6 done held", fields_done, 1);
    check("R6 ready", ratio_ready, 1);

    // R7 back-pressure: start 1000, then offer 4 while busy
    offer(16'd1000);
    ratio = 16'd4;
    ratio_valid = 1'b1;
    check("R7 ready low", ratio_ready, 0);
    while (!fields_done) begin
      check("R7 exp not from 4", base_exp, 12);
      @(negedge clk);
    end
    check("R7 first result exp", base_exp, 6);
    check("R7 first result lo", scl_lo_cnt, 7);
    @(negedge clk);
    ratio_valid = 1'b0;
    check("R7 second result exp", base_exp, 0);
    check("R7 second result lo", scl_lo_cnt, 1);
    check("R7 second result hi", scl_hi_cnt, 1);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule